// File: doc/BRIEF.md
# USB Interrupt Aggregator with Clock-Request Timer

This block sits between a USB device controller and the system interrupt controller. It takes the controller's three interrupt request lines (low priority, high priority and DMA), shows them side by side in one readable status word and merges them into a single interrupt output. A master enable bit in the same word can mask that merged output. The individual request bits stay readable while it is masked.

The block also keeps a clock-request flag that tells the system the 48 MHz USB clock must run. Bus activity, a data-pin change, a finished packet or a suspend-state change sets the flag. Two countdowns clear it, both counted in millisecond ticks supplied from outside. After traffic the countdown is `PKT_MS` ticks (5 by default). After a suspend-state change it is `SUSP_MS` ticks (2 by default). The most recent event picks which countdown runs. When the flag goes from low to high and wake-up on bus activity is selected, the block emits a one-cycle wake pulse.

Register access is plain. The write strobe and write data take effect on the next clock edge. The read data is a continuous view of the status word. None of the pins carries a data stream, so the block has no valid/ready handshake.

Top module: `usb_irq_hub`

## Requirements
- R1: Status word bits 0, 1 and 2 show the low-priority, high-priority and DMA request lines in the same cycle. With the lines at 0 after reset they read 0.
- R2: While the enable bit is 1, `irq_out` is high exactly when at least one of the three request lines is high.
- R3: Status bit 31 is the master enable. It resets to 1 and is loaded from write-data bit 31 on a write. While it is 0, `irq_out` stays low, and bits 0 to 2 still show the request lines.
- R4: The clock-request flag resets to 1. Status bit 8 and the `need_clk` output both show it.
- R5: An activity pulse or a packet-done pulse sets the flag and reloads the countdown with `PKT_MS`. The flag clears on the clock edge that samples the `PKT_MS`-th tick after the last such pulse. Each new pulse restarts the count.
- R6: A suspend-change pulse sets the flag and loads the countdown with `SUSP_MS`. The flag clears on the edge that samples the `SUSP_MS`-th tick after that pulse.
- R7: Each new event replaces the countdown that is running. If activity and suspend-change pulses arrive in the same cycle, the `PKT_MS` countdown is loaded. A tick in the same cycle as an event is ignored.
- R8: `wake_pulse` is high for exactly one cycle, the first cycle in which the flag reads 1 after having read 0. It does this only when `wake_sel` was 1 on the setting edge. An event that arrives while the flag is already 1 gives no pulse.
- R9: Writes change only bit 31. Bits 3 to 7 and 9 to 30 always read 0, and a write cannot alter the flag or bits 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_lo | input | 1 | Low-priority interrupt request line |
| req_hi | input | 1 | High-priority interrupt request line |
| req_dma | input | 1 | DMA interrupt request line |
| bus_act | input | 1 | One-cycle pulse on bus activity or data-pin change |
| pkt_done | input | 1 | One-cycle pulse when a packet was sent or received |
| susp_chg | input | 1 | One-cycle pulse on a suspend-state change |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| wake_sel | input | 1 | Enables wake pulses on flag assertion |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data; only bit 31 is used |
| reg_rdata | output | 32 | Status word read view |
| irq_out | output | 1 | Gated OR of the three request lines |
| need_clk | output | 1 | Clock-request flag |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
A wrong countdown value shows up on `need_clk` as a fall one tick early or late, or as no fall at all. It therefore becomes visible within a few milliseconds of the last event. A wrong enable state shows up at once on `irq_out` the next time any request line rises, and it shows in bit 31 of the read view on the cycle after the write. A wrong record of the previous flag value shows up on `wake_pulse` in the cycle after the setting edge, as either a missing pulse or a spurious one.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int WORD_W   = 32;
  localparam int N_LINES  = 3;
  localparam int LINE_LSB = 0;
  localparam int NEED_BIT = 8;
  localparam int EN_BIT   = 31;
  typedef enum logic [1:0] {EV_NONE, EV_TRAFFIC, EV_SUSPEND} ev_kind_t;
endpackage

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         wr_stb,
  input  logic         wr_bit,
  output logic         en_q,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b1;
    else if (wr_stb) en_q <= wr_bit;
  end

  assign irq = en_q & (|lines);
endmodule

// File: rtl/clk_req_timer.sv
module clk_req_timer
  import usb_irq_pkg::*;
#(
  parameter int PKT_MS  = 5,
  parameter int SUSP_MS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_ev,
  input  logic pkt_ev,
  input  logic susp_ev,
  input  logic tick,
  output logic need_q,
  output logic arm
);
  localparam int MAXV = (PKT_MS > SUSP_MS) ? PKT_MS : SUSP_MS;
  localparam int CW   = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q;
  ev_kind_t      ev;

  always_comb begin
    if (act_ev || pkt_ev) ev = EV_TRAFFIC;
    else if (susp_ev)     ev = EV_SUSPEND;
    else                  ev = EV_NONE;
  end

  assign arm = (ev != EV_NONE) && !need_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q <= 1'b1;
      cnt_q  <= CW'(PKT_MS);
    end else begin
      case (ev)
        EV_TRAFFIC: begin
          need_q <= 1'b1;
          cnt_q  <= CW'(PKT_MS);
        end
        EV_SUSPEND: begin
          need_q <= 1'b1;
          cnt_q  <= CW'(SUSP_MS);
        end
        default: begin
          if (need_q && tick) begin
            if (cnt_q <= CW'(1)) begin
              need_q <= 1'b0;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q - CW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/wake_edge.sv
module wake_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sel,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= arm & sel;
  end
endmodule

// File: rtl/usb_irq_hub.sv
module usb_irq_hub
  import usb_irq_pkg::*;
#(
  parameter int PKT_MS  = 5,
  parameter int SUSP_MS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_lo,
  input  logic              req_hi,
  input  logic              req_dma,
  input  logic              bus_act,
  input  logic              pkt_done,
  input  logic              susp_chg,
  input  logic              ms_tick,
  input  logic              wake_sel,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_out,
  output logic              need_clk,
  output logic              wake_pulse
);
  logic [N_LINES-1:0] lines;
  logic               en_q;
  logic               arm;

  assign lines = {req_dma, req_hi, req_lo};

  irq_merge #(.N(N_LINES)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (lines),
    .wr_stb(reg_wr),
    .wr_bit(reg_wdata[EN_BIT]),
    .en_q  (en_q),
    .irq   (irq_out)
  );

  clk_req_timer #(.PKT_MS(PKT_MS), .SUSP_MS(SUSP_MS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_ev (bus_act),
    .pkt_ev (pkt_done),
    .susp_ev(susp_chg),
    .tick   (ms_tick),
    .need_q (need_clk),
    .arm    (arm)
  );

  wake_edge u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (arm),
    .sel  (wake_sel),
    .pulse(wake_pulse)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[LINE_LSB +: N_LINES] = lines;
    reg_rdata[NEED_BIT] = need_clk;
    reg_rdata[EN_BIT]   = en_q;
  end
endmodule

// File: rtl/usb_irq_hub_chk.sv
module usb_irq_hub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_act,
  input logic        pkt_done,
  input logic        susp_chg,
  input logic        ms_tick,
  input logic        wake_sel,
  input logic [31:0] reg_rdata,
  input logic        irq_out,
  input logic        need_clk,
  input logic        wake_pulse
);
  // R2: with enable set, the output follows the OR of the visible lines
  p_or_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31] |-> (irq_out == (|reg_rdata[2:0])));

  // R3: masked output stays low
  p_mask_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[31] |-> !irq_out);

  // R4: bit 8 mirrors the flag pin
  p_flag_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[8] == need_clk);

  // R5: the flag only rises after an event
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(need_clk) |-> $past(bus_act || pkt_done || susp_chg));

  // R6: the flag only falls on a tick with no event
  p_fall_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(need_clk) |-> $past(ms_tick && !bus_act && !pkt_done && !susp_chg));

  // R8: the wake pulse is one cycle wide and marks a rise with select set
  p_wake_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  p_wake_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (need_clk && !$past(need_clk) && $past(wake_sel)));

  // R9: reserved bits read zero
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[30:9] == '0) && (reg_rdata[7:3] == '0));
endmodule

bind usb_irq_hub usb_irq_hub_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_act   (bus_act),
  .pkt_done  (pkt_done),
  .susp_chg  (susp_chg),
  .ms_tick   (ms_tick),
  .wake_sel  (wake_sel),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .need_clk  (need_clk),
  .wake_pulse(wake_pulse)
);

// File: tb/sim_usb_irq_hub.sv
`timescale 1ns/1ps
module sim_usb_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_lo = 0, req_hi = 0, req_dma = 0;
  logic        bus_act = 0, pkt_done = 0, susp_chg = 0, ms_tick = 0;
  logic        wake_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out, need_clk, wake_pulse;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_irq_hub u0 (.*);

  // entry fields: {enable, dma, hi, lo, expected irq}
  localparam logic [4:0] VEC [0:7] = '{
    5'b1_000_0, 5'b1_001_1, 5'b1_010_1, 5'b1_100_1,
    5'b1_111_1, 5'b0_111_0, 5'b0_010_0, 5'b1_011_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // kind: 0 activity, 1 packet, 2 suspend, 3 activity+suspend
  task automatic ev(input int kind);
    bus_act  = (kind == 0) || (kind == 3);
    pkt_done = (kind == 1);
    susp_chg = (kind == 2) || (kind == 3);
    step();
    bus_act = 0; pkt_done = 0; susp_chg = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      step();
      ms_tick = 1'b0;
      step();
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 R3 R4: reset state
    chk("R4 reset word", reg_rdata, 32'h8000_0100);
    chk("R4 reset flag", {31'b0, need_clk}, 32'd1);
    chk("R2 reset irq", {31'b0, irq_out}, 32'd0);
    chk("R8 reset wake", {31'b0, wake_pulse}, 32'd0);

    // R1 R2 R3: table walk
    for (int k = 0; k < 8; k++) begin
      wr({VEC[k][4], 31'b0});
      {req_dma, req_hi, req_lo} = VEC[k][3:1];
      #1;
      chk("R2/R3 irq", {31'b0, irq_out}, {31'b0, VEC[k][0]});
      chk("R1 lines", {29'b0, reg_rdata[2:0]}, {29'b0, VEC[k][3:1]});
      chk("R3 enable view", {31'b0, reg_rdata[31]}, {31'b0, VEC[k][4]});
    end
    {req_dma, req_hi, req_lo} = 3'b000;

    // R5: timeout from reset
    ticks(4);
    chk("R5 flag before 5th tick", {31'b0, need_clk}, 32'd1);
    ticks(1);
    chk("R5 flag after 5th tick", {31'b0, need_clk}, 32'd0);

    // R8: no wake without select
    ev(0);
    chk("R5 activity sets flag", {31'b0, need_clk}, 32'd1);
    chk("R8 no wake when unselected", {31'b0, wake_pulse}, 32'd0);

    // R5: restart by packet
    ticks(3);
    ev(1);
    ticks(4);
    chk("R5 restart holds flag", {31'b0, need_clk}, 32'd1);
    ticks(1);
    chk("R5 restart clears", {31'b0, need_clk}, 32'd0);

    // R8: wake with select
    wake_sel = 1'b1;
    ev(1);
    chk("R8 wake pulse", {31'b0, wake_pulse}, 32'd1);
    step();
    chk("R8 wake one cycle", {31'b0, wake_pulse}, 32'd0);
    ev(0);
    chk("R8 no wake while flag set", {31'b0, wake_pulse}, 32'd0);
    wake_sel = 1'b0;
    ticks(5);
    chk("R5 clears again", {31'b0, need_clk}, 32'd0);

    // R6: suspend countdown
    ev(2);
    ticks(1);
    chk("R6 flag after 1 tick", {31'b0, need_clk}, 32'd1);
    ticks(1);
    chk("R6 flag after 2 ticks", {31'b0, need_clk}, 32'd0);

    // R7: later activity overrides suspend
    ev(2); ev(0);
    ticks(2);
    chk("R7 activity overrides", {31'b0, need_clk}, 32'd1);
    ticks(3);
    chk("R7 activity timeout", {31'b0, need_clk}, 32'd0);

    // R7: same-cycle events load the long countdown
    ev(3);
    ticks(2);
    chk("R7 simultaneous holds", {31'b0, need_clk}, 32'd1);
    ticks(3);
    chk("R7 simultaneous clears", {31'b0, need_clk}, 32'd0);

    // R7: later suspend shortens
    ev(0); ev(2);
    ticks(2);
    chk("R7 suspend overrides", {31'b0, need_clk}, 32'd0);

    // R7: tick together with event is ignored
    bus_act = 1'b1; ms_tick = 1'b1;
    step();
    bus_act = 1'b0; ms_tick = 1'b0;
    ticks(4);
    chk("R7 tick with event ignored", {31'b0, need_clk}, 32'd1);
    ticks(1);
    chk("R7 tick with event clears", {31'b0, need_clk}, 32'd0);

    // R9: reserved writes ignored
    wr(32'hFFFF_FFFF);
    chk("R9 all-ones write", reg_rdata, 32'h8000_0000);
    wr(32'h7FFF_FFFF);
    chk("R9 clear enable only", reg_rdata, 32'h0000_0000);
    req_lo = 1'b1; #1;
    chk("R3 masked line visible", reg_rdata, 32'h0000_0001);
    chk("R3 masked irq", {31'b0, irq_out}, 32'd0);
    wr(32'h8000_0000);
    chk("R3 re-enable irq", {31'b0, irq_out}, 32'd1);
    req_lo = 1'b0;
    step();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule